// File: doc/BRIEF.md
# Privilege-Filtered Event Counter with Overflow Interrupt

This block is one counter slice of a performance monitor. On every clock it receives an event strobe, the current privilege level (0 to 3) and a global monitoring enable. It adds one to its count only when all of the following hold:

- the event strobe is high;
- monitoring is enabled;
- the bit for the current privilege level is set in the slice's mask;
- counting is not frozen.

When the count wraps from all ones to zero, the slice records an overflow. Depending on its configuration, the overflow can also:

- raise a single interrupt;
- set a freeze bit that stops further counting;
- pulse an external notification line.

Software reaches three registers through a simple register port:

- the count register;
- the configuration register;
- a status register holding the overflow and freeze bits.

Reads are combinational. Writes take effect on the clock edge. The interrupt is edge-triggered: a single wrap gives a single interrupt pulse. No new interrupt is produced while the overflow bit from an earlier wrap is still set.

Top module: `pmon_counter_slice`

## Requirements
- R1: The count rises by exactly one on a clock edge when `event_in` and `mon_en` are high, mask bit `priv_lvl` is set and the freeze bit is clear. Otherwise it holds its value.
- R2: `reg_sel` 0 selects the count register. Bits CNT_W-1:0 hold the count. Bits 63:CNT_W always read zero and ignore writes.
- R3: `reg_sel` 1 selects the configuration register, which has these fields:
  - bits 3:0: privilege mask (bit n enables level n);
  - bit 4: external-notification enable;
  - bit 5: interrupt enable;
  - bit 6: a stored flag;
  - bits 15:8: an event-select code.
  Bit 7 and bits 63:16 read zero. `reg_sel` 3 reads zero.
- R4: While the mask is all zero, the count is forced to zero from the next edge on, and writes to the count are ignored.
- R5: A wrap from all ones to zero sets status bit 0 (overflow) on the same edge. The status register is selected by `reg_sel` 2.
- R6: With the interrupt enable set, a wrap sets status bit 1 (freeze) on the same edge. It also produces a one-cycle `irq_pulse` high during the cycle that follows that edge. With the interrupt enable clear, there is no pulse and the freeze bit keeps its value.
- R7: A wrap that occurs while the overflow bit is already set produces no `irq_pulse`.
- R8: With the external-notification enable set, every wrap produces a one-cycle `ext_notify` pulse in the cycle after the wrap edge. With it clear, no pulse is produced.
- R9: While the freeze bit is set, events are ignored and the count holds.
- R10: A count write on the same edge as a qualifying event loads the written value. The event is dropped and cannot cause a wrap.
- R11: A status write loads bits 1:0 directly, so software can clear overflow or freeze. A hardware set on the same edge takes precedence over the write.
- R12: Reset clears the count, the configuration, both status bits and both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | 1 | Event occurred this cycle |
| priv_lvl | input | 2 | Current privilege level |
| mon_en | input | 1 | Global monitoring enable |
| reg_sel | input | 2 | Register select: 0 count, 1 configuration, 2 status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq_pulse | output | 1 | One-cycle overflow interrupt |
| ext_notify | output | 1 | One-cycle external overflow notification |

## Verification
The hardest case to reach from the ports is a second wrap while the overflow bit from an earlier wrap is still pending. The count has to pass all the way around again, and the freeze bit that the first wrap set would normally block any counting. The stimulus reaches this state in three steps:
1. It writes the status register so that the overflow bit stays set and the freeze bit is cleared.
2. It loads the count with all ones.
3. It applies one event.

This shows that the freeze bit and the notification fire again while the interrupt stays silent.

// File: rtl/pmon_counter_slice.sv
module pmon_counter_slice #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        event_in,
  input  logic [1:0]  priv_lvl,
  input  logic        mon_en,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        irq_pulse,
  output logic        ext_notify
);

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_CFG = 2'd1;
  localparam logic [1:0] SEL_STS = 2'd2;

  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       plm;
  logic             ev, oi, flag_q;
  logic [7:0]       evsel_q;
  logic             ovf_q, frz_q;

  logic wr_data, wr_cfg, wr_sts, cnt_step, wrap;

  assign wr_data  = reg_wr && reg_sel == SEL_CNT;
  assign wr_cfg   = reg_wr && reg_sel == SEL_CFG;
  assign wr_sts   = reg_wr && reg_sel == SEL_STS;
  assign cnt_step = event_in && mon_en && plm[priv_lvl] && !frz_q;
  assign wrap     = cnt_step && !wr_data && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plm     <= '0;
      ev      <= 1'b0;
      oi      <= 1'b0;
      flag_q  <= 1'b0;
      evsel_q <= '0;
    end else if (wr_cfg) begin
      plm     <= reg_wdata[3:0];
      ev      <= reg_wdata[4];
      oi      <= reg_wdata[5];
      flag_q  <= reg_wdata[6];
      evsel_q <= reg_wdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (plm == 4'd0)
      cnt_q <= '0;
    else if (wr_data)
      cnt_q <= reg_wdata[CNT_W-1:0];
    else if (cnt_step)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q      <= 1'b0;
      frz_q      <= 1'b0;
      irq_pulse  <= 1'b0;
      ext_notify <= 1'b0;
    end else begin
      if (wrap)
        ovf_q <= 1'b1;
      else if (wr_sts)
        ovf_q <= reg_wdata[0];
      if (wrap && oi)
        frz_q <= 1'b1;
      else if (wr_sts)
        frz_q <= reg_wdata[1];
      irq_pulse  <= wrap && oi && !ovf_q;
      ext_notify <= wrap && ev;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CNT: reg_rdata = 64'(cnt_q);
      SEL_CFG: reg_rdata = {48'd0, evsel_q, 1'b0, flag_q, oi, ev, plm};
      SEL_STS: reg_rdata = {62'd0, frz_q, ovf_q};
      default: reg_rdata = '0;
    endcase
  end

endmodule

module pmon_counter_slice_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pulse,
  input logic             ext_notify,
  input logic             ovf_q,
  input logic             frz_q,
  input logic             oi,
  input logic             ev,
  input logic [3:0]       plm,
  input logic             wr_data,
  input logic [CNT_W-1:0] cnt_q
);

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r6_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (ovf_q && frz_q));

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(oi));

  a_r7_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(ovf_q));

  a_r8_ext_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ext_notify |-> $past(ev));

  a_r9_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !wr_data && plm != 4'd0) |=> $stable(cnt_q));

  a_r4_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (plm == 4'd0) |=> (cnt_q == '0));

endmodule

bind pmon_counter_slice pmon_counter_slice_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pmon_counter_slice_tb.sv
module pmon_counter_slice_tb;
  localparam int W = 32;
  localparam logic [63:0] ONES = {W{1'b1}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        event_in = 1'b0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        mon_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_pulse, ext_notify;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pmon_counter_slice #(.CNT_W(W)) u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic events(input int n);
    @(negedge clk);
    event_in = 1'b1;
    repeat (n) @(negedge clk);
    event_in = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(2'd0, v); check("R12 count", v, 0);
    rd(2'd1, v); check("R12 config", v, 0);
    rd(2'd2, v); check("R12 status", v, 0);
    check("R12 irq", irq_pulse, 0);
    check("R12 ext", ext_notify, 0);
  endtask

  task automatic t_count();
    logic [63:0] v;
    wr(2'd1, 64'h0000_0000_0000_0034);
    mon_en = 1'b1; priv_lvl = 2'd2;
    events(5);
    rd(2'd0, v); check("R1 enabled level", v, 5);
    priv_lvl = 2'd1;
    events(3);
    rd(2'd0, v); check("R1 masked level", v, 5);
    priv_lvl = 2'd2; mon_en = 1'b0;
    events(3);
    rd(2'd0, v); check("R1 global off", v, 5);
    mon_en = 1'b1;
  endtask

  task automatic t_layout();
    logic [63:0] v;
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, v); check("R2 upper zero", v, ONES);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, v); check("R3 config readback", v, 64'h0000_0000_0000_FF7F);
    rd(2'd3, v); check("R3 unused select", v, 0);
    wr(2'd1, 64'h0000_0000_0000_0034);
  endtask

  task automatic t_overflow();
    logic [63:0] v;
    wr(2'd0, ONES);
    events(1);
    check("R6 irq pulse", irq_pulse, 1);
    check("R8 ext pulse", ext_notify, 1);
    rd(2'd0, v); check("R5 wrapped", v, 0);
    rd(2'd2, v); check("R5 R6 status", v, 3);
    @(negedge clk);
    check("R6 irq one cycle", irq_pulse, 0);
    check("R8 ext one cycle", ext_notify, 0);
  endtask

  task automatic t_freeze();
    logic [63:0] v;
    events(4);
    rd(2'd0, v); check("R9 frozen", v, 0);
  endtask

  task automatic t_pending();
    logic [63:0] v;
    int irq_seen = 0;
    wr(2'd2, 64'h1);
    rd(2'd2, v); check("R11 clear freeze", v, 1);
    wr(2'd0, ONES);
    @(negedge clk); event_in = 1'b1;
    @(negedge clk); event_in = 1'b0;
    irq_seen = irq_pulse;
    check("R7 no refire", irq_seen, 0);
    check("R8 ext again", ext_notify, 1);
    rd(2'd2, v); check("R6 freeze set again", v, 3);
  endtask

  task automatic t_no_irq_enable();
    logic [63:0] v;
    wr(2'd1, 64'h0000_0000_0000_0004);
    wr(2'd2, 64'h0);
    wr(2'd0, ONES);
    events(1);
    check("R6 no irq disabled", irq_pulse, 0);
    check("R8 no ext disabled", ext_notify, 0);
    rd(2'd2, v); check("R6 freeze unchanged", v, 1);
  endtask

  task automatic t_status_race();
    logic [63:0] v;
    wr(2'd0, ONES);
    @(negedge clk);
    event_in = 1'b1; reg_sel = 2'd2; reg_wdata = 64'h0; reg_wr = 1'b1;
    @(negedge clk);
    event_in = 1'b0; reg_wr = 1'b0;
    rd(2'd2, v); check("R11 hardware set wins", v, 1);
  endtask

  task automatic t_write_priority();
    logic [63:0] v;
    wr(2'd2, 64'h0);
    wr(2'd0, 64'd5);
    @(negedge clk);
    event_in = 1'b1; reg_sel = 2'd0; reg_wdata = 64'd9; reg_wr = 1'b1;
    @(negedge clk);
    event_in = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); check("R10 write wins", v, 9);
    wr(2'd0, ONES);
    @(negedge clk);
    event_in = 1'b1; reg_sel = 2'd0; reg_wdata = ONES; reg_wr = 1'b1;
    @(negedge clk);
    event_in = 1'b0; reg_wr = 1'b0;
    rd(2'd2, v); check("R10 dropped event no wrap", v, 0);
  endtask

  task automatic t_mask_zero();
    logic [63:0] v;
    wr(2'd0, 64'd77);
    wr(2'd1, 64'h0);
    @(negedge clk);
    rd(2'd0, v); check("R4 cleared", v, 0);
    wr(2'd0, 64'd12);
    rd(2'd0, v); check("R4 write ignored", v, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    t_reset();
    t_count();
    t_layout();
    t_overflow();
    t_freeze();
    t_pending();
    t_no_irq_enable();
    t_status_race();
    t_write_priority();
    t_mask_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule